// File: doc/BRIEF.md
# Low-Power Mode Command Sequencer

This block steps a processor through a low-power entry or exit by running a short program of byte-wide commands. The commands sit four to a 32-bit word in a small word-addressed sequence memory. Software loads the memory over a simple register bus, writes a control register with a start byte address and an enable bit, and watches a status register. Once launched, the engine fetches one byte per cycle from the start address upwards. Every byte other than the end marker comes out on a one-cycle command strobe together with its value. The end marker stops the run and sets the start address field back to zero.

The engine has three states. IDLE waits for a launch. A launch is taken when the enable bit has gone from 0 to 1 and has not been consumed yet, and it moves the engine to RUN. In RUN the engine fetches one byte per cycle. RUN goes back to IDLE when enable is low (abort), to DRAIN when the end marker is fetched, and to IDLE with the overflow flag set when the last byte of memory was a plain command. It otherwise stays in RUN and moves to the next byte. DRAIN always returns to IDLE after one cycle, so that busy falls one cycle after the end marker.

Register offsets on the 8-bit byte-addressed bus: control at 0x00, status at 0x04, identity at 0x08, and sequence word i at 0x40 + 4*i. Reads are combinational from `bus_addr`. A write is taken on the clock edge at which `bus_wr` is high. The sequence memory depth is a power-of-two number of words.

Top module: `lpm_seq_engine`

## Requirements
- R1: After reset, control and status read as zero, no command strobe is issued, and `seq_busy` is low.
- R2: A write to 0x40 + 4*i stores sequence word i, which reads back unchanged. The byte at byte address 4*i+k is bits [8k+7:8k] of that word.
- R3: The identity register at 0x08 reads the number of sequence words in bits [31:24] and zero elsewhere. Writes to it have no effect.
- R4: Writing enable (control bit 0) from 0 to 1 launches a program. The first command is strobed in the second cycle after the cycle in which the write is presented.
- R5: A running program strobes exactly one byte per cycle, at ascending byte addresses, starting at any lane and crossing word boundaries.
- R6: The byte 0x0F ends the program. It is not strobed, busy stays high for one more cycle and then falls, and the start field reads zero afterwards.
- R7: Writing enable as 1 while it already holds 1 launches nothing, even when the engine is idle.
- R8: Clearing enable during a run gives no strobe from the next cycle on and drops busy by the following cycle. The start field keeps its value.
- R9: When the last memory byte is strobed without meeting 0x0F, the run stops and status bit 1 (overflow) is set. This bit stays set until the next launch clears it.
- R10: Status holds busy in bit 0, overflow in bit 1, and in bits [15:8] the byte address most recently fetched (zero after reset). All other bits are zero.
- R11: Control holds enable in bit 0 and the start byte address in bits [13:8]. Both read back as written, apart from the clearing in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| cmd_strobe | output | 1 | One-cycle pulse per executed command |
| cmd_byte | output | 8 | Command value while `cmd_strobe` is high, else zero |
| seq_busy | output | 1 | Engine is in RUN or DRAIN |

## Verification
The assertions assume that software does not rewrite the sequence memory while a program runs. They also assume that a control write never falls in the same cycle as the end marker, since the write would then win over the clearing of the start field. The stimulus keeps to both conditions: it loads memory only while the engine is idle, and it writes control only to launch, to abort, or after waiting well past the end of a run. Every cycle, a behavioural model that keeps the memory as a flat byte array is compared against the strobe, the command byte, busy and the register read data.

// File: rtl/lpm_seq_pkg.sv
package lpm_seq_pkg;
    localparam int BUS_AW  = 8;
    localparam int DATA_W  = 32;
    localparam int CMD_W   = 8;
    localparam int LANES   = DATA_W / CMD_W;
    localparam int LANE_AW = $clog2(LANES);

    localparam logic [BUS_AW-1:0] OFS_CTRL   = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_STATUS = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_IDENT  = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_SEQ    = 8'h40;

    localparam logic [CMD_W-1:0] CMD_END = 8'h0F;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/lpm_seq_lane_mux.sv
module lpm_seq_lane_mux
    import lpm_seq_pkg::*;
(
    input  logic [DATA_W-1:0]  word_i,
    input  logic [LANE_AW-1:0] lane_i,
    output logic [CMD_W-1:0]   byte_o
);
    logic [CMD_W-1:0] lane_bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word_i[g*CMD_W +: CMD_W];
    end

    assign byte_o = lane_bytes[lane_i];
endmodule

// File: rtl/lpm_seq_regfile.sv
module lpm_seq_regfile
    import lpm_seq_pkg::*;
#(
    parameter int SEQ_WORDS = 16,
    parameter int BAW       = 6,
    parameter int WAW       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              ovf,
    input  logic [BAW-1:0]    cur_addr,
    input  logic              clr_start,
    input  logic              launch,
    input  logic [WAW-1:0]    fetch_idx,
    output logic [DATA_W-1:0] fetch_word,
    output logic              en_o,
    output logic              armed_o,
    output logic [BAW-1:0]    start_o
);
    localparam int SEQ_LO = int'(OFS_SEQ);
    localparam int SEQ_HI = SEQ_LO + 4 * SEQ_WORDS;

    logic [DATA_W-1:0] mem_q [SEQ_WORDS];
    logic              en_q, armed_q;
    logic [BAW-1:0]    start_q;
    logic              ctrl_wr, in_seq, seq_wr;
    logic [WAW-1:0]    bus_idx;

    assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
    assign in_seq  = (int'(bus_addr) >= SEQ_LO) && (int'(bus_addr) < SEQ_HI);
    assign seq_wr  = bus_wr && in_seq;
    assign bus_idx = WAW'((bus_addr - OFS_SEQ) >> 2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            armed_q <= 1'b0;
            start_q <= '0;
        end else if (ctrl_wr) begin
            en_q    <= bus_wdata[0];
            start_q <= bus_wdata[8 +: BAW];
            if (bus_wdata[0] && !en_q)
                armed_q <= 1'b1;
            else if (!bus_wdata[0] || launch)
                armed_q <= 1'b0;
        end else begin
            if (launch)
                armed_q <= 1'b0;
            if (clr_start)
                start_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SEQ_WORDS; i++)
                mem_q[i] <= '0;
        end else if (seq_wr) begin
            mem_q[bus_idx] <= bus_wdata;
        end
    end

    assign fetch_word = mem_q[fetch_idx];
    assign en_o       = en_q;
    assign armed_o    = armed_q;
    assign start_o    = start_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CTRL) begin
            bus_rdata[0]        = en_q;
            bus_rdata[8 +: BAW] = start_q;
        end else if (bus_addr == OFS_STATUS) begin
            bus_rdata[0]        = busy;
            bus_rdata[1]        = ovf;
            bus_rdata[8 +: BAW] = cur_addr;
        end else if (bus_addr == OFS_IDENT) begin
            bus_rdata[31:24] = 8'(SEQ_WORDS);
        end else if (in_seq) begin
            bus_rdata = mem_q[bus_idx];
        end
    end

    AST_END_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
        clr_start && !ctrl_wr |=> start_q == '0); // R6
    AST_SAME_EN_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && bus_wdata[0] && en_q && !armed_q |=> !armed_q); // R7
endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
    import lpm_seq_pkg::*;
#(
    parameter int BAW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             armed,
    input  logic [BAW-1:0]   start_addr,
    input  logic [CMD_W-1:0] fetch_byte,
    output logic [BAW-1:0]   ptr_o,
    output logic             busy,
    output logic             ovf,
    output logic             end_seen,
    output logic             launch,
    output logic             cmd_strobe,
    output logic [CMD_W-1:0] cmd_byte
);
    localparam logic [BAW-1:0] LAST_BYTE = '1;

    seq_state_e     state_q, state_d;
    logic [BAW-1:0] ptr_q;
    logic           ovf_q;
    logic           is_end, running;

    assign is_end = (fetch_byte == CMD_END);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (armed && en) state_d = ST_RUN;
            ST_RUN: begin
                if (!en)                     state_d = ST_IDLE;
                else if (is_end)             state_d = ST_DRAIN;
                else if (ptr_q == LAST_BYTE) state_d = ST_IDLE;
            end
            ST_DRAIN: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_RUN) begin
                ptr_q <= start_addr;
                ovf_q <= 1'b0;
            end else if (state_q == ST_RUN && en && !is_end) begin
                if (ptr_q == LAST_BYTE)
                    ovf_q <= 1'b1;
                else
                    ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    always_comb begin
        running    = (state_q == ST_RUN) && en;
        busy       = (state_q != ST_IDLE);
        cmd_strobe = running && !is_end;
        cmd_byte   = cmd_strobe ? fetch_byte : '0;
        end_seen   = running && is_end;
        launch     = (state_q == ST_IDLE) && armed && en;
        ptr_o      = ptr_q;
        ovf        = ovf_q;
    end

    AST_DRAIN_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_seen |=> busy ##1 !busy); // R6
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe && $past(cmd_strobe) |-> ptr_q == $past(ptr_q) + 1'b1); // R5
    AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |=> !busy && !cmd_strobe); // R8
    AST_OVF_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> !busy && ptr_q == LAST_BYTE); // R9
endmodule

// File: rtl/lpm_seq_engine.sv
module lpm_seq_engine
    import lpm_seq_pkg::*;
#(
    parameter int SEQ_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cmd_strobe,
    output logic [CMD_W-1:0]  cmd_byte,
    output logic              seq_busy
);
    localparam int WAW = $clog2(SEQ_WORDS);
    localparam int BAW = WAW + LANE_AW;

    logic              en, armed, ovf, end_seen, launch;
    logic [BAW-1:0]    start_addr, ptr;
    logic [DATA_W-1:0] fetch_word;
    logic [CMD_W-1:0]  fetch_byte;

    lpm_seq_regfile #(.SEQ_WORDS(SEQ_WORDS), .BAW(BAW), .WAW(WAW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (seq_busy),
        .ovf        (ovf),
        .cur_addr   (ptr),
        .clr_start  (end_seen),
        .launch     (launch),
        .fetch_idx  (ptr[BAW-1:LANE_AW]),
        .fetch_word (fetch_word),
        .en_o       (en),
        .armed_o    (armed),
        .start_o    (start_addr)
    );

    lpm_seq_lane_mux u_lane (
        .word_i (fetch_word),
        .lane_i (ptr[LANE_AW-1:0]),
        .byte_o (fetch_byte)
    );

    lpm_seq_fsm #(.BAW(BAW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .armed      (armed),
        .start_addr (start_addr),
        .fetch_byte (fetch_byte),
        .ptr_o      (ptr),
        .busy       (seq_busy),
        .ovf        (ovf),
        .end_seen   (end_seen),
        .launch     (launch),
        .cmd_strobe (cmd_strobe),
        .cmd_byte   (cmd_byte)
    );
endmodule

// File: tb/lpm_seq_engine_test.sv
module lpm_seq_engine_test;
    localparam int NW = 16;
    localparam int NB = NW * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h04;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmd_strobe;
    logic [7:0]  cmd_byte;
    logic        seq_busy;

    lpm_seq_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_strobe(cmd_strobe),
        .cmd_byte(cmd_byte), .seq_busy(seq_busy)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int w_cyc = 0;
    int first_cyc = -1;
    int last_cyc = -1;
    logic [7:0] got [$];

    // behavioural reference: flat byte memory, phase 0 idle, 1 running, 2 draining
    int         m_phase = 0;
    int         m_ptr = 0;
    int         m_start = 0;
    bit         m_en = 0, m_armed = 0, m_ovf = 0;
    logic [7:0] m_b [NB];
    bit         launch_m, end_m;

    initial foreach (m_b[i]) m_b[i] = 8'h00;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            launch_m = (m_phase == 0) && m_armed && m_en;
            end_m    = (m_phase == 1) && m_en && (m_b[m_ptr] == 8'h0F);
            case (m_phase)
                0: if (launch_m) begin m_phase = 1; m_ptr = m_start; m_ovf = 0; end
                1: begin
                    if (!m_en) m_phase = 0;
                    else if (end_m) m_phase = 2;
                    else if (m_ptr == NB - 1) begin m_phase = 0; m_ovf = 1; end
                    else m_ptr = m_ptr + 1;
                end
                default: m_phase = 0;
            endcase
            if (bus_wr && bus_addr == 8'h00) begin
                if (bus_wdata[0] && !m_en) m_armed = 1;
                else if (!bus_wdata[0] || launch_m) m_armed = 0;
                m_en = bus_wdata[0];
                m_start = int'(bus_wdata[13:8]);
            end else begin
                if (launch_m) m_armed = 0;
                if (end_m) m_start = 0;
                if (bus_wr && bus_addr >= 8'h40 && bus_addr < 8'h80) begin
                    for (int k = 0; k < 4; k++)
                        m_b[((int'(bus_addr) - 64) / 4) * 4 + k] = bus_wdata[8*k +: 8];
                end
            end
        end
    end

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00) begin r[0] = m_en; r[13:8] = 6'(m_start); end
        else if (a == 8'h04) begin r[0] = (m_phase != 0); r[1] = m_ovf; r[15:8] = 8'(m_ptr); end
        else if (a == 8'h08) r[31:24] = 8'(NW);
        else if (a >= 8'h40 && a < 8'h80) begin
            for (int k = 0; k < 4; k++) r[8*k +: 8] = m_b[((int'(a) - 64) / 4) * 4 + k];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_st;
            exp_st = (m_phase == 1) && m_en && (m_b[m_ptr] != 8'h0F);
            chk(cmd_strobe == exp_st, "R4/R5/R8 strobe", 32'(cmd_strobe), 32'(exp_st));
            if (exp_st)
                chk(cmd_byte == m_b[m_ptr], "R5 cmd_byte", 32'(cmd_byte), 32'(m_b[m_ptr]));
            chk(seq_busy == (m_phase != 0), "R6/R8 busy", 32'(seq_busy), 32'(m_phase != 0));
            chk(bus_rdata == model_rd(bus_addr), "R10/R11 rdata", bus_rdata, model_rd(bus_addr));
            if (cmd_strobe) begin
                if (got.size() == 0) first_cyc = cyc;
                last_cyc = cyc;
                got.push_back(cmd_byte);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; w_cyc = cyc;
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_addr = 8'h04;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #2;
        bus_addr = 8'h04;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clear_got();
        got.delete();
        first_cyc = -1;
        last_cyc = -1;
    endtask

    task automatic chk_bytes(input string tag, input logic [7:0] e [$]);
        chk(got.size() == e.size(), {tag, " count"}, 32'(got.size()), 32'(e.size()));
        for (int i = 0; i < e.size() && i < got.size(); i++)
            chk(got[i] == e[i], {tag, " byte"}, 32'(got[i]), 32'(e[i]));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired act=%0d exp=done", cyc);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int a_cyc;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        rd(8'h00, v); chk(v == 32'h0, "R1 ctrl after reset", v, 32'h0);
        rd(8'h04, v); chk(v == 32'h0, "R1 status after reset", v, 32'h0);
        chk(!seq_busy && !cmd_strobe, "R1 idle outputs", 32'({seq_busy, cmd_strobe}), 32'h0);

        // R3: identity register, read-only
        rd(8'h08, v); chk(v == 32'h1000_0000, "R3 ident", v, 32'h1000_0000);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk(v == 32'h1000_0000, "R3 ident after write", v, 32'h1000_0000);

        // R2: sequence words, lane packing
        wr(8'h40, 32'h2221_0000);
        wr(8'h44, 32'h0000_0F23);
        wr(8'h48, 32'h5500_0000);
        wr(8'h4C, 32'h0000_0F56);
        wr(8'h7C, 32'h0C0B_0A09);
        rd(8'h44, v); chk(v == 32'h0000_0F23, "R2 word readback", v, 32'h0000_0F23);

        // R4 R5 R6: run from byte 2 across a word boundary
        clear_got();
        wr(8'h00, 32'h0000_0201);
        idle(10);
        chk(first_cyc - w_cyc == 2, "R4 first strobe latency", 32'(first_cyc - w_cyc), 32'd2);
        chk_bytes("R5 program bytes", '{8'h21, 8'h22, 8'h23});
        rd(8'h00, v); chk(v == 32'h0000_0001, "R6 start cleared", v, 32'h1);
        rd(8'h04, v); chk(v == 32'h0000_0500, "R10 status after end", v, 32'h500);

        // R7: rewrite enable as 1
        clear_got();
        wr(8'h00, 32'h0000_0201);
        idle(8);
        chk(got.size() == 0, "R7 no relaunch", 32'(got.size()), 32'd0);
        rd(8'h00, v); chk(v == 32'h0000_0201, "R11 ctrl layout", v, 32'h201);

        // R8: abort during a long run from byte 8
        wr(8'h00, 32'h0);
        clear_got();
        wr(8'h00, 32'h0000_0801);
        idle(4);
        wr(8'h00, 32'h0000_0800);
        a_cyc = w_cyc;
        idle(6);
        chk(got.size() > 0, "R8 ran before abort", 32'(got.size()), 32'd1);
        chk(last_cyc <= a_cyc, "R8 no strobe after abort", 32'(last_cyc), 32'(a_cyc));
        chk(!seq_busy, "R8 busy dropped", 32'(seq_busy), 32'd0);
        rd(8'h00, v); chk(v == 32'h0000_0800, "R8 start kept", v, 32'h800);

        // R9: overflow from byte 61
        clear_got();
        wr(8'h00, 32'h0000_3D01);
        idle(10);
        chk_bytes("R9 tail bytes", '{8'h0A, 8'h0B, 8'h0C});
        rd(8'h04, v); chk(v == 32'h0000_3F02, "R9 overflow status", v, 32'h3F02);
        wr(8'h00, 32'h0);
        rd(8'h04, v); chk(v == 32'h0000_3F02, "R9 overflow sticky", v, 32'h3F02);
        clear_got();
        wr(8'h00, 32'h0000_0201);
        idle(10);
        chk_bytes("R9 relaunch bytes", '{8'h21, 8'h22, 8'h23});
        rd(8'h04, v); chk(v == 32'h0000_0500, "R9 overflow cleared", v, 32'h500);

        // R5: start in lane 3
        wr(8'h00, 32'h0);
        clear_got();
        wr(8'h00, 32'h0000_0B01);
        idle(8);
        chk_bytes("R5 lane3 start", '{8'h55, 8'h56});

        // R6: program that is only the end marker
        wr(8'h00, 32'h0);
        clear_got();
        wr(8'h00, 32'h0000_0501);
        idle(8);
        chk(got.size() == 0, "R6 bare end marker", 32'(got.size()), 32'd0);
        rd(8'h00, v); chk(v == 32'h0000_0001, "R6 start cleared again", v, 32'h1);

        finish_run();
    end
endmodule